// File: doc/BRIEF.md
# Page Access Permission Checker

This unit decides whether a memory access that has already been translated may go ahead. It takes the user, writable and no-execute bits from the final entry of the walk, plus that entry's 4-bit protection key. It also takes the access kind, the privilege of the requester, a handful of mode enables and a 32-bit per-key rights word. From these it forms the read/write/execute set that may be cached for the page, a single allow/deny verdict, and, on denial, the fault code bits that describe the cause.

The supervisor-side protections and the key rights are independent layers. Page bits give one permission set and the key rights give a second. The final set is their bitwise AND, and the verdict is the bit of that set that belongs to the requested access. A request is presented with a one-cycle strobe, and the outcome appears on registered outputs on the next clock edge. The page walk and the translation cache around the unit are not part of it.

Top module: `pgperm_check`

## Requirements
- R1: After reset every output is zero. `rsp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high. `allow_o`, `perm_o` and `fault_code_o` change only on that edge and otherwise hold their values.
- R2: When the privilege is user (`priv_i`=0) and the page user bit is clear, the access is denied, `perm_o` is 000, and fault code bit 0 is set.
- R3: `perm_o` bit 0 is read, bit 1 is write and bit 2 is execute. Read is granted unless the privilege is guarded supervisor (`priv_i`=2) and the page user bit is set.
- R4: Write is granted only when read is granted and either the page is writable or the privilege is not user (`priv_i`=1 or 2) with `wp_en_i` clear.
- R5: The page counts as no-execute when `pte_nx_i` and `nx_en_i` are both set. Execute is granted only when the page is not no-execute and one of three holds: the privilege is user, `xprev_en_i` is clear, or the page user bit is clear.
- R6: Key rights act only when all four hold: `pkey_en_i` and `long_mode_i` are set, the page user bit is set, and `key_rights_i` is nonzero. For key k, rights bit 2k is access-disable and bit 2k+1 is write-disable.
- R7: Access-disable removes read and write. Write-disable removes write for user privilege, and for supervisor privilege only when `wp_en_i` is set. Execute is never removed by keys. `perm_o` is the AND of the page-derived and key-derived sets.
- R8: The access kind is coded as 0 read, 1 write and 2 fetch. `allow_o` equals the `perm_o` bit of the requested kind. An allowed access has fault code 0.
- R9: A denied access sets fault code bit 0. It sets bit 1 for a write and bit 2 for user privilege. Bit 3 is always 0.
- R10: A denied fetch sets fault code bit 4 when `xprev_en_i` is set, or when `nx_en_i` and `wide_pte_i` are both set.
- R11: Fault code bit 5 is set when keys are active and the key-derived set lacks the requested bit. It is never set for a user access to a non-user page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe; inputs are sampled on this edge |
| pte_user_i | input | 1 | Combined user bit of the leaf |
| pte_write_i | input | 1 | Combined writable bit of the leaf |
| pte_nx_i | input | 1 | Combined no-execute bit of the leaf |
| pte_key_i | input | KEY_W (4) | Protection key of the leaf |
| acc_type_i | input | 2 | 0 read, 1 write, 2 fetch |
| priv_i | input | 2 | 0 user, 1 supervisor, 2 supervisor barred from user data |
| wp_en_i | input | 1 | Write-protect enable for supervisor writes |
| nx_en_i | input | 1 | No-execute enable |
| wide_pte_i | input | 1 | Extended (64-bit) entry format active |
| xprev_en_i | input | 1 | Supervisor execute prevention on user pages |
| pkey_en_i | input | 1 | Protection key enable |
| long_mode_i | input | 1 | Long mode active |
| key_rights_i | input | 2*2^KEY_W (32) | Per-key access-disable / write-disable pairs |
| rsp_valid_o | output | 1 | Result valid, one cycle after the strobe |
| allow_o | output | 1 | Access permitted |
| perm_o | output | 3 | Final permission set {exec, write, read} |
| fault_code_o | output | 6 | Fault code bits on denial, zero when allowed |

## Verification
The properties assume that `acc_type_i` and `priv_i` never carry code 3, since neither code has a meaning here. The stimulus draws these fields modulo 3, so random traffic always stays within the defined codes. The properties also take inputs as stable only on the strobe edge, so the bench changes them on falling edges. The random rights word is forced to zero in about a quarter of the draws. This exercises the case where a nonzero rights word is required for keys to act, as well as access-disable and write-disable on arbitrary keys.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPV  = 2'd1,
        PRV_GUARD = 2'd2,
        PRV_RSVD  = 2'd3
    } prv_e;

    localparam int PERM_W = 3;
    localparam int PB_RD  = 0;
    localparam int PB_WR  = 1;
    localparam int PB_EX  = 2;

    localparam int FC_W     = 6;
    localparam int FC_PROT  = 0;
    localparam int FC_WRITE = 1;
    localparam int FC_USER  = 2;
    localparam int FC_FETCH = 4;
    localparam int FC_KEY   = 5;

    typedef struct packed {
        logic              vld;
        logic              allow;
        logic [PERM_W-1:0] perm;
        logic [FC_W-1:0]   code;
    } rsp_t;

endpackage

// File: rtl/pgperm_page.sv
module pgperm_page
    import pgperm_pkg::*;
(
    input  logic              pte_user,
    input  logic              pte_write,
    input  logic              pte_nx,
    input  prv_e              priv,
    input  logic              wp_en,
    input  logic              nx_en,
    input  logic              xprev_en,
    output logic              sup_block,
    output logic [PERM_W-1:0] page_perm
);
    logic is_user;
    logic guarded;
    logic rd_ok;
    logic wr_ok;
    logic ex_ok;
    logic no_exec;

    always_comb begin
        is_user   = (priv == PRV_USER);
        guarded   = (priv == PRV_GUARD);
        no_exec   = pte_nx & nx_en;
        sup_block = is_user & ~pte_user;
        rd_ok     = ~(guarded & pte_user);
        wr_ok     = rd_ok & (pte_write | (~is_user & ~wp_en));
        ex_ok     = ~no_exec & (is_user | ~xprev_en | ~pte_user);
        page_perm = '0;
        if (!sup_block) begin
            page_perm[PB_RD] = rd_ok;
            page_perm[PB_WR] = wr_ok;
            page_perm[PB_EX] = ex_ok;
        end
    end
endmodule

// File: rtl/pgperm_key.sv
module pgperm_key
    import pgperm_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic                          pkey_en,
    input  logic                          long_mode,
    input  logic                          pte_user,
    input  logic                          is_user,
    input  logic                          wp_en,
    input  logic [KEY_W-1:0]              key,
    input  logic [2*(1<<KEY_W)-1:0]       rights,
    output logic                          keys_active,
    output logic [PERM_W-1:0]             key_perm
);
    localparam int NUM_KEYS = 1 << KEY_W;

    logic [NUM_KEYS-1:0] ad_vec;
    logic [NUM_KEYS-1:0] wd_vec;
    logic                ad_sel;
    logic                wd_sel;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_split
        assign ad_vec[k] = rights[2*k];
        assign wd_vec[k] = rights[2*k+1];
    end

    always_comb begin
        ad_sel      = ad_vec[key];
        wd_sel      = wd_vec[key];
        keys_active = pkey_en & long_mode & pte_user & (|rights);
        key_perm    = '1;
        if (keys_active) begin
            if (ad_sel) begin
                key_perm[PB_RD] = 1'b0;
                key_perm[PB_WR] = 1'b0;
            end else if (wd_sel && (is_user || wp_en)) begin
                key_perm[PB_WR] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgperm_fault.sv
module pgperm_fault
    import pgperm_pkg::*;
(
    input  acc_e              acc,
    input  logic              is_user,
    input  logic              sup_block,
    input  logic [PERM_W-1:0] final_perm,
    input  logic [PERM_W-1:0] key_perm,
    input  logic              nx_en,
    input  logic              wide_pte,
    input  logic              xprev_en,
    output logic              allow,
    output logic [FC_W-1:0]   code
);
    logic need_rd;
    logic need_wr;
    logic need_ex;
    logic key_hit;

    always_comb begin
        need_rd = (acc == ACC_READ);
        need_wr = (acc == ACC_WRITE);
        need_ex = ~need_rd & ~need_wr;
        allow   = (need_rd & final_perm[PB_RD])
                | (need_wr & final_perm[PB_WR])
                | (need_ex & final_perm[PB_EX]);
        key_hit = ~sup_block & ((need_rd & ~key_perm[PB_RD])
                              | (need_wr & ~key_perm[PB_WR])
                              | (need_ex & ~key_perm[PB_EX]));
        code = '0;
        if (!allow) begin
            code[FC_PROT]  = 1'b1;
            code[FC_WRITE] = need_wr;
            code[FC_USER]  = is_user;
            code[FC_FETCH] = (acc == ACC_FETCH) & ((nx_en & wide_pte) | xprev_en);
            code[FC_KEY]   = key_hit;
        end
    end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
    import pgperm_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid_i,
    input  logic                    pte_user_i,
    input  logic                    pte_write_i,
    input  logic                    pte_nx_i,
    input  logic [KEY_W-1:0]        pte_key_i,
    input  logic [1:0]              acc_type_i,
    input  logic [1:0]              priv_i,
    input  logic                    wp_en_i,
    input  logic                    nx_en_i,
    input  logic                    wide_pte_i,
    input  logic                    xprev_en_i,
    input  logic                    pkey_en_i,
    input  logic                    long_mode_i,
    input  logic [2*(1<<KEY_W)-1:0] key_rights_i,
    output logic                    rsp_valid_o,
    output logic                    allow_o,
    output logic [2:0]              perm_o,
    output logic [5:0]              fault_code_o
);
    acc_e              acc;
    prv_e              priv;
    logic              is_user;
    logic              sup_block;
    logic              keys_active;
    logic [PERM_W-1:0] page_perm;
    logic [PERM_W-1:0] key_perm;
    logic [PERM_W-1:0] final_perm;
    logic              allow_c;
    logic [FC_W-1:0]   code_c;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    assign acc     = acc_e'(acc_type_i);
    assign priv    = prv_e'(priv_i);
    assign is_user = (priv == PRV_USER);

    pgperm_page u_page (
        .pte_user  (pte_user_i),
        .pte_write (pte_write_i),
        .pte_nx    (pte_nx_i),
        .priv      (priv),
        .wp_en     (wp_en_i),
        .nx_en     (nx_en_i),
        .xprev_en  (xprev_en_i),
        .sup_block (sup_block),
        .page_perm (page_perm)
    );

    pgperm_key #(.KEY_W(KEY_W)) u_key (
        .pkey_en     (pkey_en_i),
        .long_mode   (long_mode_i),
        .pte_user    (pte_user_i),
        .is_user     (is_user),
        .wp_en       (wp_en_i),
        .key         (pte_key_i),
        .rights      (key_rights_i),
        .keys_active (keys_active),
        .key_perm    (key_perm)
    );

    assign final_perm = page_perm & key_perm;

    pgperm_fault u_fault (
        .acc        (acc),
        .is_user    (is_user),
        .sup_block  (sup_block),
        .final_perm (final_perm),
        .key_perm   (key_perm),
        .nx_en      (nx_en_i),
        .wide_pte   (wide_pte_i),
        .xprev_en   (xprev_en_i),
        .allow      (allow_c),
        .code       (code_c)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid_i;
        if (req_valid_i) begin
            rsp_d.allow = allow_c;
            rsp_d.perm  = final_perm;
            rsp_d.code  = code_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o  = rsp_q.vld;
    assign allow_o      = rsp_q.allow;
    assign perm_o       = rsp_q.perm;
    assign fault_code_o = rsp_q.code;

    logic unused_ok;
    assign unused_ok = keys_active;
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva #(
    parameter int KEY_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid_i,
    input logic                    pte_user_i,
    input logic                    pte_nx_i,
    input logic [1:0]              priv_i,
    input logic                    nx_en_i,
    input logic                    pkey_en_i,
    input logic                    long_mode_i,
    input logic                    rsp_valid_o,
    input logic                    allow_o,
    input logic [2:0]              perm_o,
    input logic [5:0]              fault_code_o
);
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);
    a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ($stable(allow_o) && $stable(perm_o) && $stable(fault_code_o)));
    a_r2_user_on_sup_page: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && priv_i == 2'd0 && !pte_user_i) |=>
        (!allow_o && perm_o == 3'b000 && fault_code_o[0]));
    a_r4_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !(perm_o[1] && !perm_o[0]));
    a_r5_noexec_page: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && pte_nx_i && nx_en_i) |=> !perm_o[2]);
    a_r8_allow_clean_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && allow_o) |-> (fault_code_o == 6'd0));
    a_r9_deny_sets_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !allow_o) |-> (fault_code_o[0] && !fault_code_o[3]));
    a_r11_key_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(pkey_en_i && long_mode_i)) |=> !fault_code_o[5]);
endmodule

bind pgperm_check pgperm_check_sva #(.KEY_W(KEY_W)) u_sva (.*);

// File: tb/sim_pgperm_check.sv
module sim_pgperm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        pte_user_i = 1'b0, pte_write_i = 1'b0, pte_nx_i = 1'b0;
    logic [3:0]  pte_key_i = '0;
    logic [1:0]  acc_type_i = '0, priv_i = '0;
    logic        wp_en_i = 1'b0, nx_en_i = 1'b0, wide_pte_i = 1'b0, xprev_en_i = 1'b0;
    logic        pkey_en_i = 1'b0, long_mode_i = 1'b0;
    logic [31:0] key_rights_i = '0;
    logic        rsp_valid_o, allow_o;
    logic [2:0]  perm_o;
    logic [5:0]  fault_code_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pgperm_check u0 (.*);

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=below 150000", cycles);
            finish_run();
        end
    end

    // returns {allow, perm[2:0], code[5:0]}
    function automatic logic [9:0] model(
        logic u, logic w, logic nx, logic [3:0] k, logic [1:0] acc, logic [1:0] prv,
        logic wp, logic nxe, logic wide, logic xp, logic pke, logic lm, logic [31:0] rts);
        logic [2:0] pg, ky, fin;
        logic ok, khit;
        logic [5:0] c;
        if (prv == 2'd0 && !u) pg = 3'b000;
        else begin
            pg[0] = !(prv == 2'd2 && u);
            pg[1] = pg[0] && (w || (prv != 2'd0 && !wp));
            pg[2] = !(nx && nxe) && (prv == 2'd0 || !xp || !u);
        end
        ky = 3'b111;
        if (pke && lm && u && rts != 0) begin
            if (rts[2*k]) ky = 3'b100;
            else if (rts[2*k+1] && (prv == 2'd0 || wp)) ky = 3'b101;
        end
        fin  = pg & ky;
        ok   = fin[acc];
        khit = !(prv == 2'd0 && !u) && !ky[acc];
        c = 6'd0;
        if (!ok) c = {khit, (acc == 2'd2) && ((nxe && wide) || xp), 1'b0,
                      prv == 2'd0, acc == 2'd1, 1'b1};
        return {ok, fin, c};
    endfunction

    task automatic apply(logic u, logic w, logic nx, logic [3:0] k, logic [1:0] acc,
                         logic [1:0] prv, logic wp, logic nxe, logic wide, logic xp,
                         logic pke, logic lm, logic [31:0] rts);
        @(negedge clk);
        pte_user_i = u; pte_write_i = w; pte_nx_i = nx; pte_key_i = k;
        acc_type_i = acc; priv_i = prv; wp_en_i = wp; nx_en_i = nxe;
        wide_pte_i = wide; xprev_en_i = xp; pkey_en_i = pke; long_mode_i = lm;
        key_rights_i = rts; req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    function automatic logic [9:0] got();
        return {allow_o, perm_o, fault_code_o};
    endfunction

    initial begin
        logic [9:0] held;
        // R1 reset state
        #5;
        check("R1 reset", {rsp_valid_o, allow_o, perm_o, fault_code_o}, 10'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2 user read of supervisor page: code bits 0 and 2
        apply(0,1,0,0, 2'd0,2'd0, 0,0,0,0, 0,0,0);
        check("R1 valid", {9'd0, rsp_valid_o}, 10'd1);
        check("R2 user on sup page", got(), {1'b0, 3'b000, 6'd5});
        held = got();
        @(negedge clk);
        check("R1 idle valid low", {9'd0, rsp_valid_o}, 10'd0);
        check("R1 hold", got(), held);

        // R3 guarded supervisor read of user page
        apply(1,1,0,0, 2'd0,2'd2, 0,0,0,0, 0,0,0);
        check("R3 guarded read", got(), {1'b0, 3'b100, 6'd1});
        // R4 supervisor write to read-only page, wp clear then set
        apply(0,0,0,0, 2'd1,2'd1, 0,0,0,0, 0,0,0);
        check("R4 wp clear", got(), {1'b1, 3'b111, 6'd0});
        apply(0,0,0,0, 2'd1,2'd1, 1,0,0,0, 0,0,0);
        check("R4 wp set", got(), {1'b0, 3'b101, 6'd3});
        // R5 / R10 supervisor fetch of user page with execute prevention
        apply(1,1,0,0, 2'd2,2'd1, 0,0,0,1, 0,0,0);
        check("R5 xprev fetch", got(), {1'b0, 3'b011, 6'd17});
        // R10 no-exec fetch with and without wide entries
        apply(1,1,1,0, 2'd2,2'd0, 0,1,1,0, 0,0,0);
        check("R10 nx wide", got(), {1'b0, 3'b011, 6'd21});
        apply(1,1,1,0, 2'd2,2'd0, 0,1,0,0, 0,0,0);
        check("R10 nx narrow", got(), {1'b0, 3'b011, 6'd5});
        // R5 nx bit ignored when no-execute disabled
        apply(1,1,1,0, 2'd2,2'd0, 0,0,0,0, 0,0,0);
        check("R5 nx disabled", got(), {1'b1, 3'b111, 6'd0});
        // R6 / R11 access-disable on key 3
        apply(1,1,0,4'd3, 2'd0,2'd0, 0,0,0,0, 1,1,32'h40);
        check("R11 key ad", got(), {1'b0, 3'b100, 6'd37});
        apply(1,1,0,4'd3, 2'd0,2'd0, 0,0,0,0, 1,0,32'h40);
        check("R6 no long mode", got(), {1'b1, 3'b111, 6'd0});
        apply(1,1,0,4'd3, 2'd0,2'd0, 0,0,0,0, 1,1,32'h10);
        check("R6 other key", got(), {1'b1, 3'b111, 6'd0});
        // R7 write-disable on key 2 for supervisor
        apply(1,1,0,4'd2, 2'd1,2'd1, 0,0,0,0, 1,1,32'h20);
        check("R7 wd wp clear", got(), {1'b1, 3'b111, 6'd0});
        apply(1,1,0,4'd2, 2'd1,2'd1, 1,0,0,0, 1,1,32'h20);
        check("R7 wd wp set", got(), {1'b0, 3'b101, 6'd35});

        // R8 R9 random traffic
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            logic u, w, nx, wp, nxe, wide, xp, pke, lm;
            logic [3:0] k;
            logic [1:0] acc, prv;
            logic [31:0] rts;
            logic [9:0] e;
            u = 1'($urandom); w = 1'($urandom); nx = 1'($urandom);
            wp = 1'($urandom); nxe = 1'($urandom); wide = 1'($urandom);
            xp = 1'($urandom); pke = 1'($urandom); lm = 1'($urandom);
            k = 4'($urandom);
            acc = 2'($urandom % 3); prv = 2'($urandom % 3);
            rts = ($urandom % 4 == 0) ? 32'd0 : $urandom;
            e = model(u,w,nx,k,acc,prv,wp,nxe,wide,xp,pke,lm,rts);
            apply(u,w,nx,k,acc,prv,wp,nxe,wide,xp,pke,lm,rts);
            check("R7 perm",  {7'd0, perm_o}, {7'd0, e[8:6]});
            check("R8 allow", {9'd0, allow_o}, {9'd0, e[9]});
            check("R9 code",  {4'd0, fault_code_o}, {4'd0, e[5:0]});
        end
        finish_run();
    end
endmodule